// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control sequencer of a small 8-bit processor whose instructions are one or two bytes long. It reads the byte presented by instruction memory into an instruction register, decodes the top nibble as the opcode, and steps through a short per-instruction sequence. On each step it raises the strobes the surrounding datapath needs: program-counter advance, link save, branch-target and return-address selects, register-file write, input-port select, immediate select, ALU operation, data-memory write and load-data select. For two-byte instructions it reads the second byte into an immediate register. The register indices and the immediate are passed straight through to the datapath.

The datapath advances its program counter on every cycle in which `pcEn` is high, so the memory byte seen in the next fetch or immediate-capture cycle is the next byte. After an output-port instruction, the sequencer parks in a hold state until the continue input goes high. This lets a slow observer read each result. The branch flags come from the datapath's flag register and are only consulted in the branch step.

Top module: `instrSequencer`

## Requirements
- R1: While reset is low, and in the idle state with `startIn` low, every strobe output is 0 and `aluMode` is 0; the instruction and immediate registers reset to 0.
- R2: In idle, `pcEn` equals `startIn`; the cycle after `startIn` is seen high is a fetch cycle that captures `romByte` into the instruction register.
- R3: Fields of the instruction byte: opcode is bits [7:4], ra/branch-kind is bits [3:2], rb is bits [1:0]; `raIdx` and `rbIdx` show bits [3:2] and [1:0] of the instruction register from the cycle after fetch.
- R4: Opcodes 4 (add), 5 (sub), 6 (shift left), 7 (shift right), 8 (nand) and 13 (move) take fetch, decode, execute and write-back cycles. In execute, `aluMode` is 1, 2, 3, 4, 5 and 0 respectively. Write-back raises `pcEn` and `rfWrEn`.
- R5: Opcodes 0 (no-op) and 12 (output) never raise `rfWrEn`; their write-back cycle raises only `pcEn`.
- R6: Opcode 11 (input) raises `inSel` with `aluMode` 0 in execute, then writes in write-back.
- R7: Opcodes 1, 2 and 3 raise `pcEn` in decode, capture `romByte` into the immediate register in the next cycle (`immVal`), then raise `immSel` in a load/store cycle; instruction bits [1:0] have no effect.
- R8: Opcode 2 (store) raises `ramWr`, `immSel` and `pcEn` together in its load/store cycle and then fetches, with no write-back cycle.
- R9: Opcode 1 (load) write-back raises `rfWrEn` with `wbSel`=1; opcode 3 (load immediate) write-back raises `rfWrEn` and `immSel` with `wbSel`=0.
- R10: Opcode 9 (branch) goes from decode to a branch cycle with `pcEn`=1. `brSel` is 1 for kind 0 (always) and kind 3 (call), `zFlag` for kind 1 and `nFlag` for kind 2. `lrEn` is 1 only for kind 3. The flags have no effect in any other cycle.
- R11: Opcode 14 (return) raises `pcEn` and `retSel` in decode and fetches in the next cycle.
- R12: Opcode 12 raises `outEn` in execute, then holds with all strobes low for as long as `contIn` is low. It leaves the hold at the first cycle with `contIn` high, to write-back. `contIn` has no effect outside the hold.
- R13: Undefined opcodes 10 and 15 raise only `pcEn` in decode and fetch in the next cycle.
- R14: `pcEn` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Leaves idle when high |
| contIn | input | 1 | Releases the hold after an output instruction |
| romByte | input | 8 | Byte read from instruction memory at the current PC |
| zFlag | input | 1 | Zero flag from the datapath |
| nFlag | input | 1 | Negative flag from the datapath |
| pcEn | output | 1 | Advance/load the program counter at this edge |
| lrEn | output | 1 | Save return address into the link register |
| brSel | output | 1 | Load PC from register rb |
| retSel | output | 1 | Load PC from the link register |
| rfWrEn | output | 1 | Register-file write enable |
| inSel | output | 1 | Route the input port into the ALU |
| immSel | output | 1 | Drive the immediate register onto the datapath |
| aluMode | output | 3 | ALU operation: 0 pass, 1 add, 2 sub, 3 shl, 4 shr, 5 nand |
| ramWr | output | 1 | Data-memory write |
| wbSel | output | 1 | Write-back source is memory data |
| outEn | output | 1 | Load the output port from R[ra] |
| raIdx | output | 2 | Register ra index |
| rbIdx | output | 2 | Register rb index / branch target register |
| immVal | output | 8 | Immediate register contents |

## Verification
The hardest situations to reach from the ports are those whose outcome depends on timing. One is the alignment of the second byte of two-byte instructions with the capture cycle. Another is the hold after an output instruction, with its exit on the first high continue. A third is the flag inputs mattering in exactly one cycle. The stimulus is a scripted byte stream with one entry per clock. The memory byte carries the real instruction or immediate only in the fetch and capture cycles and a junk pattern everywhere else. Both flags and the continue input are held high outside the cycles where they count, so any early sampling changes an output. Output holds of zero and several cycles are both run, and every branch kind is run with its flag both high and low.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPC_W = 4;
  localparam int IDX_W = 2;
  localparam int ALU_W = 3;

  localparam logic [OPC_W-1:0] OP_NOP  = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD = 4'd1;
  localparam logic [OPC_W-1:0] OP_STOR = 4'd2;
  localparam logic [OPC_W-1:0] OP_LDI  = 4'd3;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'd4;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'd5;
  localparam logic [OPC_W-1:0] OP_SHL  = 4'd6;
  localparam logic [OPC_W-1:0] OP_SHR  = 4'd7;
  localparam logic [OPC_W-1:0] OP_NAND = 4'd8;
  localparam logic [OPC_W-1:0] OP_BR   = 4'd9;
  localparam logic [OPC_W-1:0] OP_IN   = 4'd11;
  localparam logic [OPC_W-1:0] OP_OUT  = 4'd12;
  localparam logic [OPC_W-1:0] OP_MOV  = 4'd13;
  localparam logic [OPC_W-1:0] OP_RET  = 4'd14;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_IMM,
    ST_EXEC,
    ST_BRANCH,
    ST_LDST,
    ST_WB,
    ST_HOLD
  } seqState_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_PASS = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_SHL  = 3'd3,
    ALU_SHR  = 3'd4,
    ALU_NAND = 3'd5
  } aluOp_e;

  // Capture strobes from the sequencer to the register-holding datapath
  typedef struct packed {
    logic irLoad;
    logic immLoad;
  } capStrobe_t;

  function automatic aluOp_e aluFor(input logic [OPC_W-1:0] op);
    case (op)
      OP_ADD:  return ALU_ADD;
      OP_SUB:  return ALU_SUB;
      OP_SHL:  return ALU_SHL;
      OP_SHR:  return ALU_SHR;
      OP_NAND: return ALU_NAND;
      default: return ALU_PASS;
    endcase
  endfunction

endpackage

// File: rtl/irHold.sv
module irHold
  import seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        cap,
  input  logic [DATA_W-1:0] romByte,
  output logic [DATA_W-1:0] irWord,
  output logic [DATA_W-1:0] immWord
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irWord  <= '0;
      immWord <= '0;
    end else begin
      if (cap.irLoad)  irWord  <= romByte;
      if (cap.immLoad) immWord <= romByte;
    end
  end

endmodule

// File: rtl/ctlFsm.sv
module ctlFsm
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             contIn,
  input  logic             zFlag,
  input  logic             nFlag,
  input  logic [OPC_W-1:0] opcode,
  input  logic [IDX_W-1:0] brKind,
  output capStrobe_t       cap,
  output logic             pcEn,
  output logic             lrEn,
  output logic             brSel,
  output logic             retSel,
  output logic             rfWrEn,
  output logic             inSel,
  output logic             immSel,
  output logic [ALU_W-1:0] aluMode,
  output logic             ramWr,
  output logic             wbSel,
  output logic             outEn
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cap       = '0;
    pcEn      = 1'b0;
    lrEn      = 1'b0;
    brSel     = 1'b0;
    retSel    = 1'b0;
    rfWrEn    = 1'b0;
    inSel     = 1'b0;
    immSel    = 1'b0;
    aluMode   = ALU_PASS;
    ramWr     = 1'b0;
    wbSel     = 1'b0;
    outEn     = 1'b0;

    case (state)
      ST_IDLE: begin
        if (startIn) begin
          pcEn      = 1'b1;
          nextState = ST_FETCH;
        end
      end

      ST_FETCH: begin
        cap.irLoad = 1'b1;
        nextState  = ST_DECODE;
      end

      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STOR, OP_LDI: begin
            pcEn      = 1'b1;
            nextState = ST_IMM;
          end
          OP_BR:  nextState = ST_BRANCH;
          OP_RET: begin
            pcEn      = 1'b1;
            retSel    = 1'b1;
            nextState = ST_FETCH;
          end
          OP_NOP, OP_ADD, OP_SUB, OP_SHL, OP_SHR, OP_NAND,
          OP_IN, OP_OUT, OP_MOV: nextState = ST_EXEC;
          default: begin
            pcEn      = 1'b1;
            nextState = ST_FETCH;
          end
        endcase
      end

      ST_IMM: begin
        cap.immLoad = 1'b1;
        nextState   = ST_LDST;
      end

      ST_LDST: begin
        immSel = 1'b1;
        if (opcode == OP_STOR) begin
          ramWr     = 1'b1;
          pcEn      = 1'b1;
          nextState = ST_FETCH;
        end else begin
          nextState = ST_WB;
        end
      end

      ST_EXEC: begin
        aluMode   = aluFor(opcode);
        inSel     = (opcode == OP_IN);
        outEn     = (opcode == OP_OUT);
        nextState = (opcode == OP_OUT) ? ST_HOLD : ST_WB;
      end

      ST_HOLD: begin
        if (contIn) nextState = ST_WB;
      end

      ST_WB: begin
        pcEn      = 1'b1;
        rfWrEn    = !(opcode == OP_NOP || opcode == OP_STOR || opcode == OP_OUT);
        wbSel     = (opcode == OP_LOAD);
        immSel    = (opcode == OP_LDI);
        nextState = ST_FETCH;
      end

      ST_BRANCH: begin
        pcEn = 1'b1;
        case (brKind)
          2'd1:    brSel = zFlag;
          2'd2:    brSel = nFlag;
          default: brSel = 1'b1;
        endcase
        lrEn      = (brKind == 2'd3);
        nextState = ST_FETCH;
      end

      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/instrSequencer.sv
module instrSequencer
  import seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              contIn,
  input  logic [DATA_W-1:0] romByte,
  input  logic              zFlag,
  input  logic              nFlag,
  output logic              pcEn,
  output logic              lrEn,
  output logic              brSel,
  output logic              retSel,
  output logic              rfWrEn,
  output logic              inSel,
  output logic              immSel,
  output logic [ALU_W-1:0]  aluMode,
  output logic              ramWr,
  output logic              wbSel,
  output logic              outEn,
  output logic [IDX_W-1:0]  raIdx,
  output logic [IDX_W-1:0]  rbIdx,
  output logic [DATA_W-1:0] immVal
);

  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int RA_LSB  = IDX_W;

  capStrobe_t        capBus;
  logic [DATA_W-1:0] irWord;
  logic [DATA_W-1:0] immWord;

  irHold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rstN    (rstN),
    .cap     (capBus),
    .romByte (romByte),
    .irWord  (irWord),
    .immWord (immWord)
  );

  ctlFsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .contIn  (contIn),
    .zFlag   (zFlag),
    .nFlag   (nFlag),
    .opcode  (irWord[OPC_LSB +: OPC_W]),
    .brKind  (irWord[RA_LSB +: IDX_W]),
    .cap     (capBus),
    .pcEn    (pcEn),
    .lrEn    (lrEn),
    .brSel   (brSel),
    .retSel  (retSel),
    .rfWrEn  (rfWrEn),
    .inSel   (inSel),
    .immSel  (immSel),
    .aluMode (aluMode),
    .ramWr   (ramWr),
    .wbSel   (wbSel),
    .outEn   (outEn)
  );

  assign raIdx  = irWord[RA_LSB +: IDX_W];
  assign rbIdx  = irWord[0 +: IDX_W];
  assign immVal = immWord;

endmodule

// File: rtl/seqChecker.sv
module seqChecker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] opIn,
  input logic       pcEn,
  input logic       lrEn,
  input logic       brSel,
  input logic       retSel,
  input logic       rfWrEn,
  input logic       inSel,
  input logic       immSel,
  input logic [2:0] aluMode,
  input logic       ramWr,
  input logic       wbSel,
  input logic       outEn
);

  assert_alu_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    aluMode <= 3'd5);

  assert_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> !(opIn == 4'd0 || opIn == 4'd12));

  assert_in_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    inSel |-> (aluMode == 3'd0 && opIn == 4'd11));

  assert_store_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |-> (pcEn && immSel && !rfWrEn && opIn == 4'd2));

  assert_load_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbSel |-> (rfWrEn && opIn == 4'd1));

  assert_branch_pc_R10: assert property (@(posedge clk) disable iff (!rstN)
    brSel |-> (pcEn && opIn == 4'd9));

  assert_link_call_R10: assert property (@(posedge clk) disable iff (!rstN)
    lrEn |-> brSel);

  assert_return_R11: assert property (@(posedge clk) disable iff (!rstN)
    retSel |-> (pcEn && !brSel && opIn == 4'd14));

  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    outEn |=> (!pcEn && !outEn));

  assert_pc_single_R14: assert property (@(posedge clk) disable iff (!rstN)
    pcEn |=> !pcEn);

endmodule

bind instrSequencer seqChecker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opIn    (irWord[7:4]),
  .pcEn    (pcEn),
  .lrEn    (lrEn),
  .brSel   (brSel),
  .retSel  (retSel),
  .rfWrEn  (rfWrEn),
  .inSel   (inSel),
  .immSel  (immSel),
  .aluMode (aluMode),
  .ramWr   (ramWr),
  .wbSel   (wbSel),
  .outEn   (outEn)
);

// File: tb/test_instrSequencer.sv
`timescale 1ns/1ps
module test_instrSequencer;

  typedef struct packed {
    logic       pcEn, lrEn, brSel, retSel, rfWrEn, inSel, immSel;
    logic [2:0] aluMode;
    logic       ramWr, wbSel, outEn;
    logic [1:0] raIdx, rbIdx;
    logic [7:0] immVal;
  } obs_t;

  typedef struct packed {
    logic       start, cont, zf, nf;
    logic [7:0] rom;
  } stim_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0, contIn = 1'b0, zFlag = 1'b0, nFlag = 1'b0;
  logic [7:0] romByte = 8'h00;
  logic pcEn, lrEn, brSel, retSel, rfWrEn, inSel, immSel, ramWr, wbSel, outEn;
  logic [2:0] aluMode;
  logic [1:0] raIdx, rbIdx;
  logic [7:0] immVal;

  always #10 clk = ~clk;

  instrSequencer i_instrSequencer (
    .clk(clk), .rstN(rstN), .startIn(startIn), .contIn(contIn),
    .romByte(romByte), .zFlag(zFlag), .nFlag(nFlag),
    .pcEn(pcEn), .lrEn(lrEn), .brSel(brSel), .retSel(retSel),
    .rfWrEn(rfWrEn), .inSel(inSel), .immSel(immSel), .aluMode(aluMode),
    .ramWr(ramWr), .wbSel(wbSel), .outEn(outEn),
    .raIdx(raIdx), .rbIdx(rbIdx), .immVal(immVal)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  stim_t stimQ[$];
  obs_t  obsQ[$];
  string tagQ[$];

  logic [7:0] mIr = 8'h00;
  logic [7:0] mImm = 8'h00;
  localparam logic [7:0] JUNK = 8'hA5;

  function automatic obs_t quiet();
    obs_t o;
    o = '0;
    o.raIdx  = mIr[3:2];
    o.rbIdx  = mIr[1:0];
    o.immVal = mImm;
    return o;
  endfunction

  function automatic stim_t busy(input logic [7:0] rom);
    stim_t s;
    s.start = 1'b1; s.cont = 1'b1; s.zf = 1'b1; s.nf = 1'b1; s.rom = rom;
    return s;
  endfunction

  task automatic pushCyc(input stim_t s, input obs_t o, input string tag);
    stimQ.push_back(s);
    obsQ.push_back(o);
    tagQ.push_back(tag);
  endtask

  function automatic logic [2:0] aluExp(input logic [3:0] op);
    if (op == 4) return 3'd1;
    if (op == 5) return 3'd2;
    if (op == 6) return 3'd3;
    if (op == 7) return 3'd4;
    if (op == 8) return 3'd5;
    return 3'd0;
  endfunction

  // Reference: script of expected per-cycle outputs for one instruction
  task automatic doInstr(input logic [7:0] ir, input logic [7:0] imm,
                         input logic zf, input logic nf, input int waitCyc,
                         input string tag);
    obs_t o;
    stim_t s;
    int op;
    int kind;
    op = int'(ir[7:4]);
    kind = int'(ir[3:2]);
    // fetch
    pushCyc(busy(ir), quiet(), tag);
    mIr = ir;
    o = quiet();
    if (op == 1 || op == 2 || op == 3) begin
      o.pcEn = 1'b1;
      pushCyc(busy(JUNK), o, tag);
      pushCyc(busy(imm), quiet(), tag);
      mImm = imm;
      o = quiet();
      o.immSel = 1'b1;
      if (op == 2) begin
        o.ramWr = 1'b1;
        o.pcEn = 1'b1;
        pushCyc(busy(JUNK), o, tag);
        return;
      end
      pushCyc(busy(JUNK), o, tag);
      o = quiet();
      o.pcEn = 1'b1;
      o.rfWrEn = 1'b1;
      o.wbSel = (op == 1);
      o.immSel = (op == 3);
      pushCyc(busy(JUNK), o, tag);
    end else if (op == 9) begin
      pushCyc(busy(JUNK), o, tag);
      s = busy(JUNK);
      s.zf = zf;
      s.nf = nf;
      o = quiet();
      o.pcEn = 1'b1;
      o.brSel = (kind == 0) || (kind == 3) || (kind == 1 && zf) || (kind == 2 && nf);
      o.lrEn = (kind == 3);
      pushCyc(s, o, tag);
    end else if (op == 14) begin
      o.pcEn = 1'b1;
      o.retSel = 1'b1;
      pushCyc(busy(JUNK), o, tag);
    end else if (op == 10 || op == 15) begin
      o.pcEn = 1'b1;
      pushCyc(busy(JUNK), o, tag);
    end else begin
      pushCyc(busy(JUNK), o, tag);
      o = quiet();
      o.aluMode = aluExp(ir[7:4]);
      o.inSel = (op == 11);
      o.outEn = (op == 12);
      pushCyc(busy(JUNK), o, tag);
      if (op == 12) begin
        for (int k = 0; k < waitCyc; k++) begin
          s = busy(JUNK);
          s.cont = 1'b0;
          pushCyc(s, quiet(), tag);
        end
        pushCyc(busy(JUNK), quiet(), tag);
      end
      o = quiet();
      o.pcEn = 1'b1;
      o.rfWrEn = !(op == 0 || op == 12);
      pushCyc(busy(JUNK), o, tag);
    end
  endtask

  function automatic obs_t sample();
    obs_t g;
    g.pcEn = pcEn; g.lrEn = lrEn; g.brSel = brSel; g.retSel = retSel;
    g.rfWrEn = rfWrEn; g.inSel = inSel; g.immSel = immSel;
    g.aluMode = aluMode; g.ramWr = ramWr; g.wbSel = wbSel; g.outEn = outEn;
    g.raIdx = raIdx; g.rbIdx = rbIdx; g.immVal = immVal;
    return g;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    stim_t s;
    obs_t e;
    obs_t got;
    string t;

    // R1: reset state
    @(negedge clk);
    #1;
    checks++;
    got = sample();
    if (got !== obs_t'(0)) begin
      errors++;
      $display("FAIL R1 reset: got %h expected %h", got, obs_t'(0));
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1/R2: idle with start low, then start pulse
    for (int k = 0; k < 3; k++) begin
      s = '0;
      s.rom = JUNK;
      s.cont = 1'b1; s.zf = 1'b1; s.nf = 1'b1;
      pushCyc(s, quiet(), "R1 idle");
    end
    s = '0;
    s.start = 1'b1;
    s.rom = JUNK;
    e = quiet();
    e.pcEn = 1'b1;
    pushCyc(s, e, "R2 start");

    doInstr(8'h46, 8'h00, 0, 0, 0, "R4 R3 add");
    doInstr(8'h5B, 8'h00, 0, 0, 0, "R4 sub");
    doInstr(8'h64, 8'h00, 0, 0, 0, "R4 shl");
    doInstr(8'h7C, 8'h00, 0, 0, 0, "R4 shr");
    doInstr(8'h81, 8'h00, 0, 0, 0, "R4 nand");
    doInstr(8'hD6, 8'h00, 0, 0, 0, "R4 mov");
    doInstr(8'h03, 8'h00, 0, 0, 0, "R5 nop");
    doInstr(8'hB8, 8'h00, 0, 0, 0, "R6 in");
    doInstr(8'h37, 8'h3C, 0, 0, 0, "R7 R9 loadimm");
    doInstr(8'h1A, 8'h70, 0, 0, 0, "R7 R9 load");
    doInstr(8'h2B, 8'hC4, 0, 0, 0, "R7 R8 store");
    doInstr(8'h92, 8'h00, 0, 0, 0, "R10 br always");
    doInstr(8'h96, 8'h00, 0, 1, 0, "R10 brz not taken");
    doInstr(8'h96, 8'h00, 1, 0, 0, "R10 brz taken");
    doInstr(8'h9A, 8'h00, 1, 0, 0, "R10 brn not taken");
    doInstr(8'h9A, 8'h00, 0, 1, 0, "R10 brn taken");
    doInstr(8'h9F, 8'h00, 0, 0, 0, "R10 call");
    doInstr(8'hE0, 8'h00, 0, 0, 0, "R11 return");
    doInstr(8'hA5, 8'h00, 0, 0, 0, "R13 undef 10");
    doInstr(8'hF3, 8'h00, 0, 0, 0, "R13 undef 15");
    doInstr(8'hC8, 8'h00, 0, 0, 3, "R12 R5 out wait3");
    doInstr(8'hCC, 8'h00, 0, 0, 0, "R12 out nowait");
    doInstr(8'h3E, 8'h5A, 0, 0, 0, "R7 loadimm 2");
    doInstr(8'h41, 8'h00, 0, 0, 0, "R14 add after");

    while (stimQ.size() > 0) begin
      s = stimQ.pop_front();
      e = obsQ.pop_front();
      t = tagQ.pop_front();
      @(negedge clk);
      startIn = s.start; contIn = s.cont; zFlag = s.zf; nFlag = s.nf;
      romByte = s.rom;
      #1;
      got = sample();
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, got, e);
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

endmodule